// File: doc/BRIEF.md
# Per-Field Enabled Time and Date Alarm Comparator

This block decides when a wall-clock alarm goes off. A clock/calendar counter elsewhere supplies the present second, minute, hour (with a PM marker), month and day-of-month, all in BCD, plus a strobe that marks each seconds update. Two 32-bit alarm configuration words come from holding registers elsewhere. One word covers time of day and the other covers the date. Each field in them has its own enable bit. A field whose enable is clear is a don't-care.

On every seconds strobe, the block compares each enabled field with the present value. If at least one field is enabled and all enabled fields agree, it emits a single-cycle alarm pulse on the next cycle. It also checks the alarm words on every cycle. Each word has a registered non-valid flag that goes high when an enabled field holds an illegal BCD digit or a value outside its range. A non-valid word blocks the alarm. The legal hour range follows a 12/24-hour mode input. In 12-hour mode the PM marker is part of the hour comparison.

Top module: `alarm_cmp_top`

## Requirements
- R1: Time word layout: seconds in bits 6:0 with enable at bit 7, minutes in bits 14:8 with enable at bit 15, hour in bits 21:16, PM marker at bit 22 and hour enable at bit 23. Bits 31:24 have no effect. Each value is two BCD digits, with the tens digit in the upper bits and the units digit in bits 3:0 of the field.
- R2: Date word layout: month in bits 20:16 with enable at bit 23, day-of-month in bits 29:24 with enable at bit 31. All other bits have no effect.
- R3: If `sec_tick` is high in a cycle where at least one field is enabled and every enabled field equals its present value, `alarm_pulse` is high during the following cycle only, and then returns low.
- R4: A disabled field never blocks a match. When no field is enabled, `alarm_pulse` stays low.
- R5: `alarm_pulse` never rises unless `sec_tick` was high in the cycle before.
- R6: When `hour_mode_12` is 1 and the hour is enabled, the PM marker (bit 22) must equal `cur_pm` for a match. When `hour_mode_12` is 0, the PM marker is ignored.
- R7: `time_alarm_invalid` goes high one cycle after the time word holds an enabled field that is not legal BCD or is out of range. Seconds and minutes must be 00-59. The hour must be 00-23 in 24-hour mode and 01-12 in 12-hour mode.
- R8: `cal_alarm_invalid` goes high one cycle after the date word holds an enabled month outside 01-12, an enabled day outside 01-31, or an illegal BCD digit in an enabled field.
- R9: While either word is non-valid, no alarm pulse is produced, even when the enabled fields equal the present values.
- R10: During and right after reset, all three outputs are 0.
- R11: An illegal value in a disabled field does not make its word non-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hour_mode_12 | input | 1 | 1 selects 12-hour mode, 0 selects 24-hour mode |
| sec_tick | input | 1 | One-cycle strobe for each seconds update |
| cur_sec | input | 7 | Present seconds, BCD |
| cur_min | input | 7 | Present minutes, BCD |
| cur_hour | input | 6 | Present hour, BCD |
| cur_pm | input | 1 | Present PM marker |
| cur_month | input | 5 | Present month, BCD |
| cur_date | input | 6 | Present day of month, BCD |
| time_alarm_cfg | input | 32 | Time alarm word |
| cal_alarm_cfg | input | 32 | Date alarm word |
| alarm_pulse | output | 1 | One-cycle alarm indication |
| time_alarm_invalid | output | 1 | Time word holds an illegal enabled field |
| cal_alarm_invalid | output | 1 | Date word holds an illegal enabled field |

## Verification
The assertions assume that the configuration words and the present-time inputs change only between clock edges and are held steady around the edge on which `sec_tick` is sampled. The PM check also assumes that the mode input does not change in the same cycle as a strobe. The bench follows these rules. It changes every input on the falling edge, raises `sec_tick` for exactly one cycle per strobe, and changes the mode only in cycles without a strobe. The present-time inputs are sometimes driven with illegal BCD on purpose, to show that a non-valid alarm word still blocks the pulse.

// File: rtl/alm_cmp_pkg.sv
package alm_cmp_pkg;

  // Bit positions in the time alarm word (shared with the register block)
  localparam int T_SEC_LSB  = 0;
  localparam int T_SEC_EN   = 7;
  localparam int T_MIN_LSB  = 8;
  localparam int T_MIN_EN   = 15;
  localparam int T_HOUR_LSB = 16;
  localparam int T_PM_BIT   = 22;
  localparam int T_HOUR_EN  = 23;

  // Bit positions in the date alarm word
  localparam int C_MON_LSB  = 16;
  localparam int C_MON_EN   = 23;
  localparam int C_DATE_LSB = 24;
  localparam int C_DATE_EN  = 31;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int MON_W  = 5;
  localparam int DATE_W = 6;
  localparam int LIM_W  = 7;

  // Two-digit BCD legality and range test (tens digit above bit 3).
  function automatic logic bcd_in_range(input logic [LIM_W-1:0] v,
                                        input logic [LIM_W-1:0] lo,
                                        input logic [LIM_W-1:0] hi);
    logic [LIM_W-1:0] bin;
    bin = LIM_W'(v[LIM_W-1:4]) * LIM_W'(10) + LIM_W'(v[3:0]);
    return (v[3:0] <= 4'd9) && (bin >= lo) && (bin <= hi);
  endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
  import alm_cmp_pkg::*;
#(
  parameter int W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [W-1:0]     alm,
  input  logic [W-1:0]     cur,
  input  logic             use_tag,
  input  logic             alm_tag,
  input  logic             cur_tag,
  input  logic [LIM_W-1:0] lo,
  input  logic [LIM_W-1:0] hi,
  output logic             hit,
  output logic             bad
);

  logic legal;
  logic same;

  always_comb begin
    legal = bcd_in_range(LIM_W'(alm), lo, hi);
    same  = (alm == cur) && (!use_tag || (alm_tag == cur_tag));
    bad   = en && !legal;
    hit   = !en || same;
  end

  // R3: an enabled field reporting a hit must really agree with the present value
  hit_needs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit) |-> (alm == cur));

  // R11: only an enabled field may flag its word as non-valid
  bad_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> en);

endmodule

// File: rtl/alm_pulse_gen.sv
module alm_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fire,
  input  logic tbad,
  input  logic cbad,
  output logic pulse,
  output logic tbad_q,
  output logic cbad_q
);

  logic pulse_d;
  logic tbad_d;
  logic cbad_d;
  logic flag_en;

  always_comb begin
    flag_en = 1'b1;
    pulse_d = tick && fire;
    tbad_d  = tbad;
    cbad_d  = cbad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      tbad_q <= 1'b0;
      cbad_q <= 1'b0;
    end else begin
      pulse <= pulse_d;
      if (flag_en) begin
        tbad_q <= tbad_d;
        cbad_q <= cbad_d;
      end
    end
  end

endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hour_mode_12,
  input  logic              sec_tick,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic              cur_pm,
  input  logic [MON_W-1:0]  cur_month,
  input  logic [DATE_W-1:0] cur_date,
  input  logic [31:0]       time_alarm_cfg,
  input  logic [31:0]       cal_alarm_cfg,
  output logic              alarm_pulse,
  output logic              time_alarm_invalid,
  output logic              cal_alarm_invalid
);

  logic [LIM_W-1:0] hr_lo;
  logic [LIM_W-1:0] hr_hi;
  logic sec_hit, min_hit, hr_hit, mon_hit, date_hit;
  logic sec_bad, min_bad, hr_bad, mon_bad, date_bad;
  logic any_en, all_hit, tbad_c, cbad_c, fire;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{time_alarm_cfg[31:24], cal_alarm_cfg[15:0],
                             cal_alarm_cfg[22:21], cal_alarm_cfg[30]};

  always_comb begin
    hr_lo = hour_mode_12 ? LIM_W'(1)  : LIM_W'(0);
    hr_hi = hour_mode_12 ? LIM_W'(12) : LIM_W'(23);
  end

  alm_field_cmp #(.W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .en(time_alarm_cfg[T_SEC_EN]),
    .alm(time_alarm_cfg[T_SEC_LSB +: SEC_W]), .cur(cur_sec),
    .use_tag(1'b0), .alm_tag(1'b0), .cur_tag(1'b0),
    .lo(LIM_W'(0)), .hi(LIM_W'(59)), .hit(sec_hit), .bad(sec_bad));

  alm_field_cmp #(.W(MIN_W)) u_min (
    .clk(clk), .rst_n(rst_n), .en(time_alarm_cfg[T_MIN_EN]),
    .alm(time_alarm_cfg[T_MIN_LSB +: MIN_W]), .cur(cur_min),
    .use_tag(1'b0), .alm_tag(1'b0), .cur_tag(1'b0),
    .lo(LIM_W'(0)), .hi(LIM_W'(59)), .hit(min_hit), .bad(min_bad));

  alm_field_cmp #(.W(HOUR_W)) u_hour (
    .clk(clk), .rst_n(rst_n), .en(time_alarm_cfg[T_HOUR_EN]),
    .alm(time_alarm_cfg[T_HOUR_LSB +: HOUR_W]), .cur(cur_hour),
    .use_tag(hour_mode_12), .alm_tag(time_alarm_cfg[T_PM_BIT]), .cur_tag(cur_pm),
    .lo(hr_lo), .hi(hr_hi), .hit(hr_hit), .bad(hr_bad));

  alm_field_cmp #(.W(MON_W)) u_month (
    .clk(clk), .rst_n(rst_n), .en(cal_alarm_cfg[C_MON_EN]),
    .alm(cal_alarm_cfg[C_MON_LSB +: MON_W]), .cur(cur_month),
    .use_tag(1'b0), .alm_tag(1'b0), .cur_tag(1'b0),
    .lo(LIM_W'(1)), .hi(LIM_W'(12)), .hit(mon_hit), .bad(mon_bad));

  alm_field_cmp #(.W(DATE_W)) u_date (
    .clk(clk), .rst_n(rst_n), .en(cal_alarm_cfg[C_DATE_EN]),
    .alm(cal_alarm_cfg[C_DATE_LSB +: DATE_W]), .cur(cur_date),
    .use_tag(1'b0), .alm_tag(1'b0), .cur_tag(1'b0),
    .lo(LIM_W'(1)), .hi(LIM_W'(31)), .hit(date_hit), .bad(date_bad));

  always_comb begin
    any_en  = time_alarm_cfg[T_SEC_EN] || time_alarm_cfg[T_MIN_EN] ||
              time_alarm_cfg[T_HOUR_EN] || cal_alarm_cfg[C_MON_EN] ||
              cal_alarm_cfg[C_DATE_EN];
    all_hit = sec_hit && min_hit && hr_hit && mon_hit && date_hit;
    tbad_c  = sec_bad || min_bad || hr_bad;
    cbad_c  = mon_bad || date_bad;
    fire    = any_en && all_hit && !tbad_c && !cbad_c;
  end

  alm_pulse_gen u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .fire(fire),
    .tbad(tbad_c), .cbad(cbad_c),
    .pulse(alarm_pulse), .tbad_q(time_alarm_invalid), .cbad_q(cal_alarm_invalid));

  // R5
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(sec_tick));

  // R9
  pulse_entries_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> (!time_alarm_invalid && !cal_alarm_invalid));

  // R4
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(any_en));

  // R6
  pulse_pm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_pulse && $past(hour_mode_12) && $past(time_alarm_cfg[T_HOUR_EN]))
      |-> ($past(time_alarm_cfg[T_PM_BIT]) == $past(cur_pm)));

endmodule

// File: tb/alarm_cmp_top_bench.sv
module alarm_cmp_top_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hour_mode_12 = 1'b0;
  logic sec_tick = 1'b0;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic cur_pm = 1'b0;
  logic [4:0] cur_month = 5'h01;
  logic [5:0] cur_date = 6'h01;
  logic [31:0] time_alarm_cfg = '0;
  logic [31:0] cal_alarm_cfg = '0;
  logic alarm_pulse, time_alarm_invalid, cal_alarm_invalid;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  alarm_cmp_top u_alarm_cmp_top (
    .clk(clk), .rst_n(rst_n), .hour_mode_12(hour_mode_12), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_pm(cur_pm),
    .cur_month(cur_month), .cur_date(cur_date),
    .time_alarm_cfg(time_alarm_cfg), .cal_alarm_cfg(cal_alarm_cfg),
    .alarm_pulse(alarm_pulse), .time_alarm_invalid(time_alarm_invalid),
    .cal_alarm_invalid(cal_alarm_invalid));

  function automatic logic [31:0] tword(logic [6:0] s, logic se, logic [6:0] m, logic me,
                                        logic [5:0] h, logic pm, logic he);
    return {8'h00, he, pm, h, me, m, se, s};
  endfunction

  function automatic logic [31:0] cword(logic [5:0] d, logic de, logic [4:0] mo, logic moe);
    return {de, 1'b0, d, moe, 2'b00, mo, 16'h0000};
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One strobe; pulse expected in the next cycle, low in the one after (R3)
  task automatic strobe(string req, logic exp);
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    chk(req, alarm_pulse, exp);
    @(negedge clk);
    chk({req, " R3 single"}, alarm_pulse, 1'b0);
  endtask

  task automatic set_cfg(logic [31:0] tw, logic [31:0] cw);
    @(negedge clk);
    time_alarm_cfg = tw;
    cal_alarm_cfg  = cw;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 pulse", alarm_pulse, 1'b0);
    chk("R10 tinv", time_alarm_invalid, 1'b0);
    chk("R10 cinv", cal_alarm_invalid, 1'b0);
  endtask

  task automatic t_seconds;
    cur_sec = 7'h30;
    set_cfg(tword(7'h30, 1, 7'h00, 0, 6'h00, 0, 0), '0);
    strobe("R1 sec match", 1'b1);
    cur_sec = 7'h31;
    strobe("R1 sec mismatch", 1'b0);
  endtask

  task automatic t_multi;
    cur_sec = 7'h45; cur_min = 7'h17; cur_hour = 6'h21;
    set_cfg(tword(7'h45, 1, 7'h17, 1, 6'h21, 0, 1), '0);
    strobe("R3 all match", 1'b1);
    cur_min = 7'h18;
    strobe("R3 minute differs", 1'b0);
  endtask

  task automatic t_dont_care;
    cur_min = 7'h15; cur_sec = 7'h02; cur_hour = 6'h05;
    set_cfg(tword(7'h00, 0, 7'h15, 1, 6'h00, 0, 0), '0);
    strobe("R4 disabled fields", 1'b1);
    set_cfg('0, '0);
    strobe("R4 nothing enabled", 1'b0);
  endtask

  task automatic t_no_tick;
    cur_min = 7'h15;
    set_cfg(tword(7'h00, 0, 7'h15, 1, 6'h00, 0, 0), '0);
    repeat (3) @(negedge clk);
    chk("R5 no strobe", alarm_pulse, 1'b0);
  endtask

  task automatic t_pm;
    @(negedge clk) hour_mode_12 = 1'b1;
    cur_hour = 6'h11; cur_pm = 1'b0;
    set_cfg(tword(7'h00, 0, 7'h00, 0, 6'h11, 1, 1), '0);
    strobe("R6 12h pm differs", 1'b0);
    cur_pm = 1'b1;
    strobe("R6 12h pm equal", 1'b1);
    @(negedge clk) hour_mode_12 = 1'b0;
    cur_pm = 1'b0;
    set_cfg(tword(7'h00, 0, 7'h00, 0, 6'h11, 1, 1), '0);
    strobe("R6 24h pm ignored", 1'b1);
  endtask

  task automatic t_time_bad;
    set_cfg(tword(7'h60, 1, 7'h00, 0, 6'h00, 0, 0), '0);
    chk("R7 sec 60", time_alarm_invalid, 1'b1);
    set_cfg(tword(7'h00, 0, 7'h5A, 1, 6'h00, 0, 0), '0);
    chk("R7 min bad digit", time_alarm_invalid, 1'b1);
    set_cfg(tword(7'h59, 1, 7'h59, 1, 6'h24, 0, 1), '0);
    chk("R7 24h hour 24", time_alarm_invalid, 1'b1);
    set_cfg(tword(7'h59, 1, 7'h59, 1, 6'h23, 0, 1), '0);
    chk("R7 24h hour 23", time_alarm_invalid, 1'b0);
    @(negedge clk) hour_mode_12 = 1'b1;
    set_cfg(tword(7'h00, 0, 7'h00, 0, 6'h13, 0, 1), '0);
    chk("R7 12h hour 13", time_alarm_invalid, 1'b1);
    set_cfg(tword(7'h00, 0, 7'h00, 0, 6'h00, 0, 1), '0);
    chk("R7 12h hour 00", time_alarm_invalid, 1'b1);
    set_cfg(tword(7'h00, 0, 7'h00, 0, 6'h12, 0, 1), '0);
    chk("R7 12h hour 12", time_alarm_invalid, 1'b0);
    @(negedge clk) hour_mode_12 = 1'b0;
  endtask

  task automatic t_cal;
    set_cfg('0, cword(6'h00, 0, 5'h13, 1));
    chk("R8 month 13", cal_alarm_invalid, 1'b1);
    set_cfg('0, cword(6'h00, 0, 5'h00, 1));
    chk("R8 month 00", cal_alarm_invalid, 1'b1);
    set_cfg('0, cword(6'h32, 1, 5'h00, 0));
    chk("R8 date 32", cal_alarm_invalid, 1'b1);
    set_cfg('0, cword(6'h0B, 1, 5'h00, 0));
    chk("R8 date bad digit", cal_alarm_invalid, 1'b1);
    cur_month = 5'h12; cur_date = 6'h31;
    set_cfg('0, cword(6'h31, 1, 5'h12, 1));
    chk("R8 date 31 month 12", cal_alarm_invalid, 1'b0);
    strobe("R2 date match", 1'b1);
    set_cfg(32'hFF00_0000, cword(6'h31, 1, 5'h12, 1) | 32'h4060_FFFF);
    chk("R2 stray bits no effect", cal_alarm_invalid, 1'b0);
    strobe("R2 stray bits match", 1'b1);
  endtask

  task automatic t_blocked;
    cur_sec = 7'h60;
    set_cfg(tword(7'h60, 1, 7'h00, 0, 6'h00, 0, 0), '0);
    strobe("R9 bad time entry", 1'b0);
    cur_sec = 7'h10; cur_month = 5'h04;
    set_cfg(tword(7'h10, 1, 7'h00, 0, 6'h00, 0, 0), cword(6'h40, 1, 5'h04, 1));
    strobe("R9 bad date entry", 1'b0);
  endtask

  task automatic t_disabled_illegal;
    set_cfg(tword(7'h7F, 0, 7'h7F, 0, 6'h3F, 1, 0), cword(6'h3F, 0, 5'h1F, 0));
    chk("R11 time word", time_alarm_invalid, 1'b0);
    chk("R11 date word", cal_alarm_invalid, 1'b0);
  endtask

  initial begin
    fork
      begin
        #2 t_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_multi();
        t_dont_care();
        t_no_tick();
        t_pm();
        t_time_bad();
        t_cal();
        t_blocked();
        t_disabled_illegal();
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule